// File: doc/BRIEF.md
# Prioritized Edge/Level Interrupt Controller

This block collects interrupt requests for a single core from three groups of sources: external request lines, internal timer events and inter-processor events. Each source has its own enable bit, priority and vector. The external lines can each be set to edge or level sensing. Timer and inter-processor sources always use edge sensing. The block picks the best eligible request and drives one interrupt line to the core. When the core pulses acknowledge, the block returns the vector of that request in the same cycle.

The priorities of the interrupts now being serviced are kept on a small stack. An acknowledge pushes the granted priority and an end-of-interrupt pops the top entry. The block only interrupts the core for a request whose priority is strictly above the top of that stack. The vector returned on acknowledge and the pending bit cleared on that edge come from the same view of the requests. That view includes edges that arrive in the acknowledge cycle itself. A higher-priority edge that lands in the acknowledge window is therefore granted once and cleared once, and is not delivered a second time after its end-of-interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_o` is low, the in-service stack is empty, and an acknowledge returns `spur_vec_i`.
- R2: An edge-sensed source latches a pending state on a 0-to-1 transition of its line. The pending state stays set when the line falls and stays set while the source is disabled. It is cleared only when that source is granted by an acknowledge.
- R3: A level-sensed external source (its `ext_level_i` bit is 1) requests only while its line is high. After end-of-interrupt it requests again only if the line is still high.
- R4: Sources are numbered with external lines at indices 0..N_EXT-1, then timers, then inter-processor events. Timer and inter-processor sources are always edge-sensed, so a line held high delivers only once.
- R5: Among enabled, requesting sources, the highest priority wins. Equal priorities go to the lowest index. Priority 0 never requests.
- R6: `irq_o` is high only when the winning priority is strictly greater than the top of the in-service stack (0 when the stack is empty). A higher priority therefore preempts a lower one that is in service.
- R7: When `ack_i` is high and `irq_o` is high, `ack_vec_o` gives the winner's vector from `src_vec_i` (8 bits per source, source i at bits [8i+7:8i]) in the same cycle. The clock edge then clears that source's pending state and pushes its priority.
- R8: If a higher-priority edge arrives in the same cycle as an acknowledge, that source is the one granted and cleared. The lower-priority source stays pending. After end-of-interrupt the higher source is not delivered again.
- R9: An acknowledge while `irq_o` is low returns `spur_vec_i` and changes no pending or in-service state.
- R10: Each `eoi_i` pulse pops the top in-service priority. An `eoi_i` with an empty stack has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_req_i | input | N_EXT | External request lines |
| tmr_evt_i | input | N_TMR | Timer event lines (edge) |
| ipi_evt_i | input | N_IPI | Inter-processor event lines (edge) |
| ext_level_i | input | N_EXT | 1 = level sense, 0 = edge sense, per external line |
| src_en_i | input | NSRC | Per-source enable |
| src_prio_i | input | NSRC*PRIO_W | Per-source priority, 0 = masked |
| src_vec_i | input | NSRC*VEC_W | Per-source vector |
| spur_vec_i | input | VEC_W | Vector returned when nothing is eligible |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the core |
| ack_vec_o | output | VEC_W | Vector valid while `ack_i` is high |

## Verification
The bench uses the default build: four external lines, two timers, two inter-processor sources, 4-bit priorities and 8-bit vectors. This gives eight sources, so an edge source, a level source and both fixed-edge groups can all be active in one scenario. It also gives enough priority levels to nest three deep and to test equal-priority ties. The acknowledge-window race is driven by raising a timer line in the exact cycle the core acknowledges a pending lower external source.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;
endpackage

// File: rtl/prio_irq_pend.sv
module prio_irq_pend
  import prio_irq_pkg::*;
#(
  parameter int N_EXT = 4,
  parameter int NSRC  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  line_i,
  input  logic [N_EXT-1:0] level_i,
  input  logic [NSRC-1:0]  clr_i,
  output logic [NSRC-1:0]  req_o
);
  logic [NSRC-1:0] prev_q, pend_q, pend_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    sense_e sense;
    logic   edge_now;
    if (i < N_EXT) begin : g_cfg
      assign sense = level_i[i] ? SENSE_LEVEL : SENSE_EDGE;
    end else begin : g_fix
      assign sense = SENSE_EDGE;
    end
    assign edge_now = line_i[i] & ~prev_q[i];
    always_comb begin
      if (sense == SENSE_LEVEL) begin
        req_o[i]  = line_i[i];
        pend_d[i] = 1'b0;
      end else begin
        req_o[i]  = pend_q[i] | edge_now;
        pend_d[i] = (pend_q[i] | edge_now) & ~clr_i[i];
      end
    end

    // R2
    pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense == SENSE_EDGE && pend_q[i] && !clr_i[i]) |=> pend_q[i]);
    // R7
    pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] |=> !pend_q[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= line_i;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]        req_i,
  input  logic [NSRC-1:0]        en_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  output logic                   win_valid_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output logic [PRIO_W-1:0]      win_prio_o
);
  // strict compare: prio 0 never wins, ties keep lowest index
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_prio_o  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && en_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > win_prio_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_isr_stack.sv
module prio_irq_isr_stack #(
  parameter int PRIO_W = 4,
  localparam int DEPTH = (1 << PRIO_W) - 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic [PRIO_W-1:0] top_prio_o
);
  logic [PRIO_W-1:0] stk_q [DEPTH+1];
  logic [CNT_W-1:0]  cnt_q, cnt_pop;

  assign cnt_pop    = (pop_i && cnt_q != '0) ? cnt_q - CNT_W'(1) : cnt_q;
  assign top_prio_o = (cnt_q == '0) ? '0 : stk_q[cnt_q - CNT_W'(1)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i <= DEPTH; i++) stk_q[i] <= '0;
    end else begin
      if (push_i) stk_q[cnt_pop] <= push_prio_i;
      cnt_q <= cnt_pop + (push_i ? CNT_W'(1) : CNT_W'(0));
    end
  end

  // R10
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R10
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q == '0) |=> cnt_q == '0);
  // R6
  push_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> push_prio_i > top_prio_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_EXT  = 4,
  parameter int N_TMR  = 2,
  parameter int N_IPI  = 2,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8,
  localparam int NSRC  = N_EXT + N_TMR + N_IPI,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_EXT-1:0]       ext_req_i,
  input  logic [N_TMR-1:0]       tmr_evt_i,
  input  logic [N_IPI-1:0]       ipi_evt_i,
  input  logic [N_EXT-1:0]       ext_level_i,
  input  logic [NSRC-1:0]        src_en_i,
  input  logic [NSRC*PRIO_W-1:0] src_prio_i,
  input  logic [NSRC*VEC_W-1:0]  src_vec_i,
  input  logic [VEC_W-1:0]       spur_vec_i,
  input  logic                   ack_i,
  input  logic                   eoi_i,
  output logic                   irq_o,
  output logic [VEC_W-1:0]       ack_vec_o
);
  logic [NSRC-1:0]   line, req, clr;
  logic              win_valid, grant, take;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio, isr_top;

  assign line = {ipi_evt_i, tmr_evt_i, ext_req_i};

  prio_irq_pend #(.N_EXT(N_EXT), .NSRC(NSRC)) i_pend (
    .clk_i, .rst_ni, .line_i(line), .level_i(ext_level_i),
    .clr_i(clr), .req_o(req)
  );

  prio_irq_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) i_arb (
    .req_i(req), .en_i(src_en_i), .prio_i(src_prio_i),
    .win_valid_o(win_valid), .win_idx_o(win_idx), .win_prio_o(win_prio)
  );

  prio_irq_isr_stack #(.PRIO_W(PRIO_W)) i_stack (
    .clk_i, .rst_ni, .push_i(take), .push_prio_i(win_prio),
    .pop_i(eoi_i), .top_prio_o(isr_top)
  );

  // one snapshot drives vector, clear and push
  assign grant     = win_valid && (win_prio > isr_top);
  assign irq_o     = grant;
  assign take      = ack_i && grant;
  assign clr       = take ? (NSRC'(1) << win_idx) : '0;
  assign ack_vec_o = take ? src_vec_i[int'(win_idx)*VEC_W +: VEC_W] : spur_vec_i;

  // R7
  ack_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !eoi_i) |=> isr_top == $past(win_prio));
  // R9
  spur_nochg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !eoi_i) |=> $stable(isr_top));
  // R6
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (win_valid && win_prio != '0));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int NE = 4, NT = 2, NI = 2, PW = 4, VW = 8;
  localparam int NS = NE + NT + NI;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NE-1:0] ext_req, lvl;
  logic [NT-1:0] tmr;
  logic [NI-1:0] ipi;
  logic [NS-1:0] en;
  logic [NS*PW-1:0] prio;
  logic [NS*VW-1:0] vec;
  logic ack, eoi, irq;
  logic [VW-1:0] ack_vec;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.N_EXT(NE), .N_TMR(NT), .N_IPI(NI), .PRIO_W(PW), .VEC_W(VW)) i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni, .ext_req_i(ext_req), .tmr_evt_i(tmr), .ipi_evt_i(ipi),
    .ext_level_i(lvl), .src_en_i(en), .src_prio_i(prio), .src_vec_i(vec),
    .spur_vec_i(8'hFF), .ack_i(ack), .eoi_i(eoi), .irq_o(irq), .ack_vec_o(ack_vec)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; ext_req = '0; lvl = '0; tmr = '0; ipi = '0;
    en = '0; prio = '0; ack = 1'b0; eoi = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic cfg(int idx, int p);
    prio[idx*PW +: PW] = PW'(p);
    en[idx] = 1'b1;
  endtask

  task automatic do_ack(string tag, logic [7:0] exp);
    ack = 1'b1; #1;
    chk(tag, ack_vec, exp);
    tick();
    ack = 1'b0; #1;
  endtask

  task automatic do_eoi();
    eoi = 1'b1; tick(); eoi = 1'b0; #1;
  endtask

  task automatic t_reset();
    do_reset(); #1;
    chk("R1 irq after reset", irq, 0);
    do_ack("R1 spurious after reset", 8'hFF);
    chk("R1 irq stays low", irq, 0);
  endtask

  task automatic t_edge();
    do_reset();
    cfg(0, 3);
    ext_req[0] = 1'b1; tick(); ext_req[0] = 1'b0; tick(); #1;
    chk("R2 edge latched after line fell", irq, 1);
    en[0] = 1'b0; tick(); #1;
    chk("R2 disabled hides request", irq, 0);
    en[0] = 1'b1; #1;
    chk("R2 pending kept while disabled", irq, 1);
    do_ack("R7 edge vector", 8'h10);
    chk("R6 no irq at same priority in service", irq, 0);
    do_eoi();
    chk("R2 pending cleared by ack", irq, 0);
    do_ack("R2 nothing left", 8'hFF);
  endtask

  task automatic t_level();
    do_reset();
    lvl[1] = 1'b1; cfg(1, 2); #1;
    chk("R3 low level line idle", irq, 0);
    ext_req[1] = 1'b1; #1;
    chk("R3 level line requests", irq, 1);
    do_ack("R3 level vector", 8'h11);
    chk("R6 level in service", irq, 0);
    do_eoi();
    chk("R3 re-request while high", irq, 1);
    do_ack("R3 second vector", 8'h11);
    ext_req[1] = 1'b0;
    do_eoi();
    chk("R3 no request once low", irq, 0);
  endtask

  task automatic t_fixed_edge();
    do_reset();
    cfg(5, 4); cfg(7, 6);
    tmr[1] = 1'b1; #1;
    chk("R4 timer requests", irq, 1);
    do_ack("R4 timer vector", 8'h15);
    do_eoi();
    chk("R4 held timer line no redelivery", irq, 0);
    ipi[1] = 1'b1; #1;
    do_ack("R4 ipi vector", 8'h17);
    do_eoi();
    chk("R4 held ipi line no redelivery", irq, 0);
  endtask

  task automatic t_race();
    do_reset();
    cfg(0, 2); cfg(4, 5);
    ext_req[0] = 1'b1; tick(); ext_req[0] = 1'b0; #1;
    tmr[0] = 1'b1;
    do_ack("R8 late higher edge wins ack", 8'h14);
    chk("R8 lower pending masked by in-service", irq, 0);
    do_eoi();
    chk("R8 lower still pending", irq, 1);
    do_ack("R8 no duplicate, lower delivered", 8'h10);
    do_eoi();
    chk("R8 nothing after both retired", irq, 0);
    do_ack("R8 no duplicate timer", 8'hFF);
  endtask

  task automatic t_arb();
    do_reset();
    cfg(1, 4); cfg(2, 4); cfg(3, 0);
    ext_req[3:1] = 3'b111; tick(); ext_req[3:1] = '0; #1;
    do_ack("R5 tie goes to lowest index", 8'h11);
    chk("R5 equal priority does not preempt", irq, 0);
    do_eoi();
    do_ack("R5 tie loser next", 8'h12);
    do_eoi();
    chk("R5 priority 0 masked", irq, 0);
    cfg(0, 1); cfg(6, 7);
    ext_req[0] = 1'b1; ipi[0] = 1'b1; tick(); ext_req[0] = 1'b0; ipi[0] = 1'b0; #1;
    do_ack("R5 highest priority wins", 8'h16);
    do_eoi();
    do_ack("R5 lower after higher", 8'h10);
    do_eoi();
  endtask

  task automatic t_nest();
    do_reset();
    cfg(0, 2); cfg(3, 1); cfg(6, 6);
    ext_req[0] = 1'b1; tick(); ext_req[0] = 1'b0; #1;
    do_ack("R6 first level", 8'h10);
    ext_req[3] = 1'b1; tick(); ext_req[3] = 1'b0; #1;
    chk("R6 lower priority blocked", irq, 0);
    ipi[0] = 1'b1; tick(); ipi[0] = 1'b0; #1;
    chk("R6 higher preempts", irq, 1);
    do_ack("R6 nested vector", 8'h16);
    do_eoi();
    chk("R10 pop one level only", irq, 0);
    do_ack("R9 spurious when blocked", 8'hFF);
    do_eoi();
    chk("R9 spurious pushed nothing", irq, 1);
    do_ack("R10 last pending", 8'h13);
    do_eoi();
    do_eoi();
    chk("R10 eoi on empty stack", irq, 0);
    ext_req[3] = 1'b1; tick(); ext_req[3] = 1'b0; #1;
    chk("R10 stack empty after extra eoi", irq, 1);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) vec[i*VW +: VW] = VW'(8'h10 + i);
    t_reset();
    t_edge();
    t_level();
    t_fixed_edge();
    t_race();
    t_arb();
    t_nest();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule